// File: doc/BRIEF.md
# Programmable Waveform State Engine

This block is a small microcoded sequencer for a parallel capture interface. A host fills a 128-byte waveform memory that holds four waveform programs. Each program has seven working states and an idle state. A working state is either a hold state or a decision state. A hold state stays put for a programmed number of interface clocks. A decision state spends one clock and branches on a logic function of two selectable flag terms. In every working state the engine drives six control outputs, and it can latch the external data bus into a FIFO write port.

The host chooses which waveform serves a FIFO read through a select register, loads a transaction count and pulses a trigger. A decision state can mark its exit to idle as a re-execution point. The program then runs again from its first state until the transaction count is used up. A done output is high whenever the engine rests in the idle state.

Top module: `wave_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` is 1, `fifo_wr` is 0 and `ctl_out` is 0.
- R2: While the engine is idle, `ctl_out` takes the value of `idle_ctl` one clock later.
- R3: Memory byte address bits [6:5] pick the waveform, bits [4:3] pick the group (0 length/branch, 1 opcode, 2 output, 3 logic function) and bits [2:0] pick the state. A trigger starts the waveform named by select bits [1:0] at state 0; select bits [7:2] have no effect on a FIFO read run.
- R4: A hold state (opcode bit 0 clear) lasts L clocks for a length byte L of 1 to 255, and 256 clocks for L = 0. It then moves to the next state number, and state 6 moves to idle.
- R5: Opcode bit 1 set makes every clock of the state sample `bus_in`. The sample appears on `fifo_wdata` with `fifo_wr` high one clock later. No write occurs while idle.
- R6: Bits [5:0] of a state's output byte appear on `ctl_out` one clock after each clock spent in that state.
- R7: A decision state (opcode bit 0 set) lasts one clock. It goes to branch bits [5:3] when its condition is 1 and to bits [2:0] when it is 0.
- R8: Logic byte bits [7:6] choose the operation: 0 A AND B, 1 A OR B, 2 A XOR B, 3 (NOT A) AND B. Bits [5:3] select term A and bits [2:0] select term B. Term codes 0 to 5 read `flag_in` bits 0 to 5, code 6 reads `fifo_full` and code 7 reads a constant 0.
- R9: A branch to idle with branch bit 7 set restarts at state 0 and decrements the count when the count exceeds 1. Otherwise the count goes to 0 and the engine goes idle. A branch to idle with bit 7 clear ends the run and leaves the count unchanged.
- R10: A trigger while idle makes `done` go low on the next clock. `done` stays low for exactly the number of clocks spent in working states.
- R11: A trigger or a count load that arrives while the engine is busy is ignored, and the count never rises during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Waveform memory write strobe |
| cfg_addr | input | 7 | Waveform memory byte address |
| cfg_wdata | input | 8 | Waveform memory write data |
| sel_we | input | 1 | Waveform select register write strobe |
| sel_wdata | input | 8 | Waveform select value; bits [1:0] serve FIFO read |
| tc_we | input | 1 | Transaction count load strobe (idle only) |
| tc_wdata | input | TC_W | Transaction count value |
| idle_ctl | input | CTL_W | Control output value while idle |
| trig | input | 1 | Start a FIFO read run (idle only) |
| flag_in | input | 6 | External flag terms, codes 0 to 5 |
| fifo_full | input | 1 | FIFO full flag, term code 6 |
| bus_in | input | DATA_W | External data bus |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | Sampled bus word |
| ctl_out | output | CTL_W | Control outputs |
| done | output | 1 | High while the engine is idle |

## Verification
The main run is tried with a multi-pass program whose exit re-executes on the count. It is also tried with a single pass whose hold length is 0, with a seven-state chain of one-clock holds, and with a capture loop that ends only when the full flag rises mid-run. Together these separate counted restarts from plain exits, the 256-clock case from the literal length, and sequential stepping from branching. A two-way branch program is run under every logic operation and under flag patterns that make the condition true or false, including the full-flag and constant-zero term codes. The run length tells the taken path apart. Stray triggers and count loads during a run show up as a changed run length or a changed count for the following run.

// File: rtl/wave_pkg.sv
package wave_pkg;
  localparam int ST_BITS  = 3;
  localparam int WF_BITS  = 2;
  localparam int GRP_BITS = 2;
  localparam int FLAG_N   = 6;
  localparam logic [ST_BITS-1:0] ST_IDLE = 3'd7;

  typedef enum logic [GRP_BITS-1:0] {
    G_LEN   = 2'd0,
    G_OPC   = 2'd1,
    G_OUT   = 2'd2,
    G_LOGIC = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    OP_AND   = 2'd0,
    OP_OR    = 2'd1,
    OP_XOR   = 2'd2,
    OP_NA_B  = 2'd3
  } lop_e;

  localparam int OPC_DP    = 0;
  localparam int OPC_DATA  = 1;
  localparam int BR_REEXEC = 7;
endpackage

// File: rtl/wave_bank.sv
module wave_bank #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wave_logic.sv
module wave_logic
  import wave_pkg::*;
(
  input  logic [FLAG_N-1:0] flag_in,
  input  logic              fifo_full,
  input  logic [7:0]        lbyte,
  output logic              cond
);
  logic [7:0] terms;
  logic       ta, tb;
  lop_e       op;

  always_comb begin
    terms = {1'b0, fifo_full, flag_in};
    ta    = terms[lbyte[5:3]];
    tb    = terms[lbyte[2:0]];
    op    = lop_e'(lbyte[7:6]);
    unique case (op)
      OP_AND:  cond = ta & tb;
      OP_OR:   cond = ta | tb;
      OP_XOR:  cond = ta ^ tb;
      OP_NA_B: cond = ~ta & tb;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/wave_engine.sv
module wave_engine
  import wave_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TC_W   = 16,
  parameter int CTL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              sel_we,
  input  logic [7:0]        sel_wdata,
  input  logic              tc_we,
  input  logic [TC_W-1:0]   tc_wdata,
  input  logic [CTL_W-1:0]  idle_ctl,
  input  logic              trig,
  input  logic [5:0]        flag_in,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] bus_in,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              done
);
  localparam int GRP_N   = 1 << GRP_BITS;
  localparam int BANK_AW = WF_BITS + ST_BITS;

  logic [ST_BITS-1:0] st_q, st_d;
  logic [7:0]         cnt_q, cnt_d;
  logic [TC_W-1:0]    tc_q, tc_d;
  logic [WF_BITS-1:0] wf_q, wf_d;
  logic [7:0]         sel_q;
  logic [7:0]         grp_byte [GRP_N];
  logic               busy, cond, is_dp, samp;
  logic [ST_BITS-1:0] tgt;
  logic [7:0]         len_b, opc_b, out_b, lg_b;

  for (genvar g = 0; g < GRP_N; g++) begin : g_bank
    wave_bank #(.AW(BANK_AW), .DW(8)) u_bank (
      .clk   (clk),
      .we    (cfg_we && (cfg_addr[4:3] == GRP_BITS'(g))),
      .waddr ({cfg_addr[6:5], cfg_addr[2:0]}),
      .wdata (cfg_wdata),
      .raddr ({wf_q, st_q}),
      .rdata (grp_byte[g])
    );
  end

  assign len_b = grp_byte[G_LEN];
  assign opc_b = grp_byte[G_OPC];
  assign out_b = grp_byte[G_OUT];
  assign lg_b  = grp_byte[G_LOGIC];
  assign busy  = (st_q != ST_IDLE);
  assign is_dp = opc_b[OPC_DP];
  assign samp  = opc_b[OPC_DATA];
  assign done  = ~busy;

  wave_logic u_logic (
    .flag_in   (flag_in),
    .fifo_full (fifo_full),
    .lbyte     (lg_b),
    .cond      (cond)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tc_d  = tc_q;
    wf_d  = wf_q;
    tgt   = cond ? len_b[5:3] : len_b[2:0];
    if (!busy) begin
      if (tc_we) tc_d = tc_wdata;
      if (trig) begin
        st_d  = '0;
        cnt_d = '0;
        wf_d  = sel_q[WF_BITS-1:0];
      end
    end else if (is_dp) begin
      cnt_d = '0;
      if ((tgt == ST_IDLE) && len_b[BR_REEXEC]) begin
        if (tc_q > TC_W'(1)) begin
          tc_d = tc_q - TC_W'(1);
          st_d = '0;
        end else begin
          tc_d = '0;
          st_d = ST_IDLE;
        end
      end else begin
        st_d = tgt;
      end
    end else begin
      if (cnt_q == len_b - 8'd1) begin
        cnt_d = '0;
        st_d  = st_q + ST_BITS'(1);
      end else begin
        cnt_d = cnt_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      tc_q       <= '0;
      wf_q       <= '0;
      sel_q      <= '0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      ctl_out    <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      tc_q    <= tc_d;
      wf_q    <= wf_d;
      if (sel_we) sel_q <= sel_wdata;
      fifo_wr <= busy && samp;
      if (busy && samp) fifo_wdata <= bus_in;
      ctl_out <= busy ? out_b[CTL_W-1:0] : idle_ctl;
    end
  end
endmodule

// File: rtl/wave_engine_chk.sv
module wave_engine_chk #(
  parameter int CTL_W = 6,
  parameter int TC_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             done,
  input logic             fifo_wr,
  input logic [CTL_W-1:0] idle_ctl,
  input logic [CTL_W-1:0] ctl_out,
  input logic [TC_W-1:0]  tc_q
);
  p_idle_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(done)) |-> (ctl_out == $past(idle_ctl)));

  p_no_idle_wr_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(!done));

  p_trig_start_r10: assert property (@(posedge clk) disable iff (rst)
    (done && trig) |=> !done);

  p_tc_no_rise_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!done) && !done) |-> (tc_q <= $past(tc_q)));

  p_tc_step_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!done) && (tc_q != $past(tc_q)))
      |-> (tc_q == $past(tc_q) - TC_W'(1)));
endmodule

bind wave_engine wave_engine_chk #(.CTL_W(CTL_W), .TC_W(TC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trig     (trig),
  .done     (done),
  .fifo_wr  (fifo_wr),
  .idle_ctl (idle_ctl),
  .ctl_out  (ctl_out),
  .tc_q     (tc_q)
);

// File: tb/tb_wave_engine.sv
`timescale 1ns/1ps
module tb_wave_engine;
  localparam int DATA_W = 16;
  localparam int TC_W   = 16;
  localparam int CTL_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [6:0]        cfg_addr = '0;
  logic [7:0]        cfg_wdata = '0;
  logic              sel_we = 1'b0;
  logic [7:0]        sel_wdata = '0;
  logic              tc_we = 1'b0;
  logic [TC_W-1:0]   tc_wdata = '0;
  logic [CTL_W-1:0]  idle_ctl = '0;
  logic              trig = 1'b0;
  logic [5:0]        flag_in = '0;
  logic              fifo_full = 1'b0;
  logic [DATA_W-1:0] bus_in = '0;
  logic              fifo_wr;
  logic [DATA_W-1:0] fifo_wdata;
  logic [CTL_W-1:0]  ctl_out;
  logic              done;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [CTL_W-1:0]  expc_q[$];
  logic [CTL_W-1:0]  clog [0:15];

  always #2 clk = ~clk;

  wave_engine #(.DATA_W(DATA_W), .TC_W(TC_W), .CTL_W(CTL_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1 bus_in = bus_in + 1'b1;
    end
  end

  // scoreboard monitor: R5 data, R6 outputs during sampling
  initial begin
    forever begin
      @(negedge clk);
      if (fifo_wr) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected write", int'(fifo_wdata), -1);
        end else begin
          logic [DATA_W-1:0] e;
          logic [CTL_W-1:0]  ec;
          e  = exp_q.pop_front();
          ec = expc_q.pop_front();
          chk(fifo_wdata == e, "R5 sample", int'(fifo_wdata), int'(e));
          chk(ctl_out == ec, "R6 ctl while sampling", int'(ctl_out), int'(ec));
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wbyte(input int wf, input int grp, input int st, input logic [7:0] v);
    cfg_we    = 1'b1;
    cfg_addr  = 7'((wf << 5) | (grp << 3) | st);
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wstate(input int wf, input int st, input logic [7:0] lb, input logic [7:0] opc,
                        input logic [7:0] ob, input logic [7:0] lg);
    wbyte(wf, 0, st, lb);
    wbyte(wf, 1, st, opc);
    wbyte(wf, 2, st, ob);
    wbyte(wf, 3, st, lg);
  endtask

  task automatic setsel(input logic [7:0] v);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic settc(input int v);
    tc_we = 1'b1; tc_wdata = TC_W'(v);
    @(negedge clk);
    tc_we = 1'b0;
  endtask

  // start a run, predict samples, measure busy clocks
  task automatic run(input string req, input int exp_busy, input int passes, input int per,
                     input int spp, input logic [CTL_W-1:0] sctl, input int full_after,
                     input bit poke, input logic [CTL_W-1:0] cnt_ctl, output int hits);
    logic [DATA_W-1:0] k;
    int n, seen;
    trig = 1'b1;
    k = bus_in;
    for (int p = 0; p < passes; p++)
      for (int j = 1; j <= spp; j++) begin
        exp_q.push_back(k + DATA_W'(p * per + j));
        expc_q.push_back(sctl);
      end
    @(negedge clk);
    trig = 1'b0;
    n = 0; seen = 0; hits = 0;
    while (!done && n < 5000) begin
      if (n < 16) clog[n] = ctl_out;
      if (ctl_out == cnt_ctl) hits++;
      if (fifo_wr) seen++;
      if (full_after > 0 && seen == full_after) fifo_full = 1'b1;
      if (poke && n == 5) begin trig = 1'b1; tc_we = 1'b1; tc_wdata = 16'd9; end
      if (poke && n == 6) begin trig = 1'b0; tc_we = 1'b0; end
      n++;
      @(negedge clk);
    end
    if (n < 16) clog[n] = ctl_out;
    if (ctl_out == cnt_ctl) hits++;
    trig = 1'b0; tc_we = 1'b0; fifo_full = 1'b0;
    chk(n == exp_busy, {req, " busy clocks"}, n, exp_busy);
    chk(exp_q.size() == 0, {req, " pending samples"}, exp_q.size(), 0);
    exp_q.delete(); expc_q.delete();
    @(negedge clk);
  endtask

  task automatic branch_case(input string req, input logic [7:0] lg, input logic [5:0] fl,
                             input logic ff, input int exp_busy);
    int h;
    wbyte(3, 3, 0, lg);
    flag_in = fl;
    run(req, exp_busy, 0, 0, 0, '0, 0, 0, 6'h3F, h);
    fifo_full = ff;
    flag_in = '0;
  endtask

  initial begin
    int h;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b1, "R1 done in reset", int'(done), 1);
    chk(fifo_wr == 1'b0, "R1 no write in reset", int'(fifo_wr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && fifo_wr == 1'b0, "R1 after reset", int'({done, fifo_wr}), 2);
    chk(ctl_out == 6'h00, "R1 ctl after reset", int'(ctl_out), 0);
    for (int a = 0; a < 128; a++) begin
      cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = 8'h00;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    // R2 idle value
    idle_ctl = 6'h2A;
    @(negedge clk);
    @(negedge clk);
    chk(ctl_out == 6'h2A, "R2 idle ctl", int'(ctl_out), 'h2A);

    // R3 R9 R6: waveform 2, three counted passes, upper select bits junk
    wstate(2, 0, 8'd3, 8'h02, 8'h15, 8'h00);
    wstate(2, 1, 8'hBF, 8'h01, 8'h22, 8'h00);
    setsel(8'hF6);
    settc(3);
    run("R9 R3 reexec", 12, 3, 4, 3, 6'h15, 0, 1'b1, 6'h22, h);
    chk(h == 3, "R6 decision output seen per pass", h, 3);
    // R11: poke during previous run ignored, count now spent -> one pass
    run("R11 busy load ignored", 4, 1, 4, 3, 6'h15, 0, 1'b0, 6'h00, h);

    // R4 length 0 = 256, R9 no reexec ignores count
    wstate(1, 0, 8'd0, 8'h02, 8'h3F, 8'h00);
    wstate(1, 1, 8'h3F, 8'h01, 8'h00, 8'h00);
    setsel(8'h01);
    settc(5);
    run("R4 length zero", 257, 1, 257, 256, 6'h3F, 0, 1'b0, 6'h00, h);

    // R4 R6 sequential chain S0..S6 to idle
    for (int s = 0; s < 7; s++) wstate(1, s, 8'd1, 8'h00, 8'(s + 1), 8'h00);
    run("R4 chain", 7, 0, 0, 0, '0, 0, 1'b0, 6'h00, h);
    chk(clog[0] == 6'h2A, "R2 ctl before first state", int'(clog[0]), 'h2A);
    for (int s = 1; s <= 7; s++)
      chk(clog[s] == 6'(s), "R6 chain ctl order", int'(clog[s]), s);

    // R7 R8: capture loop ended by full flag (AND of term 6 with itself)
    wstate(0, 0, 8'd1, 8'h02, 8'h07, 8'h00);
    wstate(0, 1, 8'hB8, 8'h01, 8'h00, 8'h36);
    setsel(8'h00);
    settc(1);
    run("R7 full flag loop", 10, 5, 2, 1, 6'h07, 5, 1'b0, 6'h00, h);

    // R8 logic operations: true path 2 clocks, false path 4 clocks
    wstate(3, 0, 8'h11, 8'h01, 8'h00, 8'h01);
    wstate(3, 1, 8'd2, 8'h00, 8'h00, 8'h00);
    wstate(3, 2, 8'h3F, 8'h01, 8'h00, 8'h00);
    setsel(8'h03);
    branch_case("R8 AND true",  8'h01, 6'b000011, 1'b0, 2);
    branch_case("R8 AND false", 8'h01, 6'b000001, 1'b0, 4);
    branch_case("R8 OR true",   8'h41, 6'b000010, 1'b0, 2);
    branch_case("R8 OR false",  8'h41, 6'b000000, 1'b0, 4);
    branch_case("R8 XOR false", 8'h81, 6'b000011, 1'b0, 4);
    branch_case("R8 XOR true",  8'h81, 6'b000001, 1'b0, 2);
    branch_case("R8 NOTA AND B true",  8'hC1, 6'b000010, 1'b0, 2);
    branch_case("R8 NOTA AND B false", 8'hC1, 6'b000011, 1'b0, 4);
    branch_case("R8 term5",     8'h2D, 6'b100000, 1'b0, 2);
    fifo_full = 1'b1;
    branch_case("R8 term6 full", 8'h36, 6'b000000, 1'b0, 2);
    fifo_full = 1'b1;
    branch_case("R8 term7 zero", 8'h7F, 6'b111111, 1'b0, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule